// File: doc/BRIEF.md
# NAND Controller Register Front End

This block is the register interface of a NAND flash controller. A host reads and writes a small set of 32-bit registers through a simple single-cycle bus. The registers are a control word, two timing words, a sticky status word, a page counter and a command port. The block drives one interrupt line. The pin sequencer, ECC, DMA and the data FIFO are outside the block. The data register is a stub that passes reads and writes straight through to an external FIFO.

To issue a command, software sets the run bit in the control word. This raises the command-request status flag. Software then writes three command words in a row to the command port. After the third accepted write, the block presents all three words to the command engine together with a one-cycle valid pulse. Single-cycle event pulses from the engine become sticky status bits. Software clears them by writing ones. A status bit raises the interrupt only when its mask bit in the control word is 0, so a 1 in a mask bit disables that interrupt.

Top module: `nand_regfront`

## Requirements
- R1: After reset, the control word reads 0x00000FFF, and status, page count and `irq` are all 0.
- R2: Writing the status register (offset 0x14) clears each status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R3: An `evt_in[k]` pulse sets status bit k at the next clock edge. If an event and a write-one-to-clear hit the same bit in the same cycle, the event wins.
- R4: `irq` is 1 exactly when some status bit k is 1 while control bit k (k in 0..11) is 0.
- R5: A control write (offset 0x00) that sets bit 28 (run) while run is 0 sets status bit 0 (command request).
- R6: With run at 1, the third write to offset 0x48 makes `cmd_valid` high for exactly the next cycle. At that point `cmd_words[31:0]`, `[63:32]` and `[95:64]` hold the first, second and third words. Reads of 0x48, 0x4C and 0x50 return those words.
- R7: The first command word accepted after run is set clears status bit 0.
- R8: Writes to 0x48 while run is 0 are ignored and do not advance the word counter. Writes to 0x4C and 0x50 are always ignored.
- R9: A control write with bit 28 at 0 aborts a partly loaded command and returns the word counter to zero.
- R10: The page counter (offset 0x18) adds one for each of status event bits 10 and 9 pulsed in a cycle. A control write with bit 20 set zeroes it. A control write with bit 19 set pulses `ecc_clr` for one cycle, starting one cycle later. Bits 20 and 19 of the control word always read 0.
- R11: A write to offset 0x40 drives `fifo_wr` with `fifo_wdata` equal to the bus data in the same cycle. A read of 0x40 drives `fifo_rd` in the same cycle and returns `fifo_rdata`.
- R12: Read data appears on `bus_rdata` one cycle after the read request. The timing words at 0x04 and 0x0C read back what was written and appear on `timing0` and `timing1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| evt_in | input | 12 | Event pulses from the engine, one per status bit |
| cmd_valid | output | 1 | One-cycle pulse when a full command is loaded |
| cmd_words | output | 96 | The three command words, first word in the low bits |
| ctrl_word | output | 32 | Current control word |
| timing0 | output | 32 | Timing word 0 |
| timing1 | output | 32 | Timing word 1 |
| ecc_clr | output | 1 | One-cycle ECC clear pulse |
| fifo_wr | output | 1 | Data FIFO write strobe |
| fifo_wdata | output | 32 | Data FIFO write data |
| fifo_rd | output | 1 | Data FIFO read strobe |
| fifo_rdata | input | 32 | Data FIFO read data |
| irq | output | 1 | Interrupt request |

## Verification
A word counter that is off by one shows up directly at the ports. `cmd_valid` fires after the first or second write instead of the third, or the words land in the wrong slices of `cmd_words`. Either error is visible in the cycle after the write concerned. An abort that does not reset the counter is caught the same way on the very next command. A wrong set/clear priority in the status register is seen on the next status read. A wrong mask polarity is seen on `irq` in the cycle after the event is registered.

// File: rtl/nrf_pkg.sv
package nrf_pkg;
    localparam int REG_W = 32;

    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_TIM0  = 8'h04;
    localparam logic [7:0] OFF_TIM1  = 8'h0C;
    localparam logic [7:0] OFF_STAT  = 8'h14;
    localparam logic [7:0] OFF_PGCNT = 8'h18;
    localparam logic [7:0] OFF_DATA  = 8'h40;
    localparam logic [7:0] OFF_CMD0  = 8'h48;

    localparam int CTL_RUN     = 28;
    localparam int CTL_CLR_PG  = 20;
    localparam int CTL_CLR_ECC = 19;

    localparam int ST_CMDREQ   = 0;
    localparam int ST_PG_CS0   = 10;
    localparam int ST_PG_CS1   = 9;
endpackage

// File: rtl/nrf_status.sv
module nrf_status #(
    parameter int STAT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_vec,
    input  logic [STAT_W-1:0] clr_vec,
    input  logic [STAT_W-1:0] mask,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic [STAT_W-1:0] st_d, st_q;

    always_comb begin
        st_d = (st_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = st_q;
    assign irq    = |(st_q & ~mask);
endmodule

// File: rtl/nrf_cmdbuf.sv
module nrf_cmdbuf #(
    parameter int NUM_WORDS = 3,
    parameter int WORD_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        accept,
    input  logic                        abort,
    input  logic [WORD_W-1:0]           wdata,
    output logic [NUM_WORDS*WORD_W-1:0] words,
    output logic                        issue,
    output logic                        first_word
);
    localparam int CNT_W = (NUM_WORDS > 2) ? $clog2(NUM_WORDS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_WORDS - 1);

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] w;
        logic [CNT_W-1:0]                 cnt;
        logic                             valid;
    } cb_t;

    cb_t cb_d, cb_q;

    always_comb begin
        cb_d       = cb_q;
        cb_d.valid = 1'b0;
        if (abort) begin
            cb_d.cnt = '0;
        end else if (accept) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (cb_q.cnt == CNT_W'(i)) cb_d.w[i] = wdata;
            end
            if (cb_q.cnt == LAST) begin
                cb_d.cnt   = '0;
                cb_d.valid = 1'b1;
            end else begin
                cb_d.cnt = cb_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cb_q <= '0;
        else        cb_q <= cb_d;
    end

    assign words      = cb_q.w;
    assign issue      = cb_q.valid;
    assign first_word = accept && !abort && (cb_q.cnt == '0);
endmodule

// File: rtl/nand_regfront.sv
module nand_regfront
    import nrf_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int STAT_W    = 12,
    parameter int CMD_WORDS = 3,
    parameter int PGCNT_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [REG_W-1:0]           bus_wdata,
    output logic [REG_W-1:0]           bus_rdata,
    input  logic [STAT_W-1:0]          evt_in,
    output logic                       cmd_valid,
    output logic [CMD_WORDS*REG_W-1:0] cmd_words,
    output logic [REG_W-1:0]           ctrl_word,
    output logic [REG_W-1:0]           timing0,
    output logic [REG_W-1:0]           timing1,
    output logic                       ecc_clr,
    output logic                       fifo_wr,
    output logic [REG_W-1:0]           fifo_wdata,
    output logic                       fifo_rd,
    input  logic [REG_W-1:0]           fifo_rdata,
    output logic                       irq
);
    localparam logic [REG_W-1:0] CTRL_RST = REG_W'((64'd1 << STAT_W) - 64'd1);
    localparam logic [REG_W-1:0] SELF_CLR = (REG_W'(1) << CTL_CLR_PG) | (REG_W'(1) << CTL_CLR_ECC);

    typedef struct packed {
        logic [REG_W-1:0]   ctrl;
        logic [REG_W-1:0]   tim0;
        logic [REG_W-1:0]   tim1;
        logic [PGCNT_W-1:0] pgcnt;
        logic [REG_W-1:0]   rdata;
        logic               ecc_clr;
    } rf_t;

    rf_t rf_d, rf_q;

    logic              wr_ctrl, wr_stat, wr_cmd, run_q, run_rise, abort_cmd, cmd_accept;
    logic              first_word;
    logic [STAT_W-1:0] set_vec, clr_vec, stat_bits;

    assign wr_ctrl    = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
    assign wr_stat    = bus_wr && (bus_addr == ADDR_W'(OFF_STAT));
    assign wr_cmd     = bus_wr && (bus_addr == ADDR_W'(OFF_CMD0));
    assign run_q      = rf_q.ctrl[CTL_RUN];
    assign run_rise   = wr_ctrl && bus_wdata[CTL_RUN] && !run_q;
    assign abort_cmd  = wr_ctrl && !bus_wdata[CTL_RUN];
    assign cmd_accept = wr_cmd && run_q;

    assign set_vec = evt_in | (run_rise ? STAT_W'(1) << ST_CMDREQ : '0);
    assign clr_vec = (wr_stat ? bus_wdata[STAT_W-1:0] : '0)
                   | (first_word ? STAT_W'(1) << ST_CMDREQ : '0);

    nrf_status #(.STAT_W(STAT_W)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .clr_vec(clr_vec),
        .mask   (rf_q.ctrl[STAT_W-1:0]),
        .status (stat_bits),
        .irq    (irq)
    );

    nrf_cmdbuf #(.NUM_WORDS(CMD_WORDS), .WORD_W(REG_W)) u_cmdbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (cmd_accept),
        .abort     (abort_cmd),
        .wdata     (bus_wdata),
        .words     (cmd_words),
        .issue     (cmd_valid),
        .first_word(first_word)
    );

    always_comb begin
        rf_d         = rf_q;
        rf_d.ecc_clr = 1'b0;
        if (wr_ctrl) begin
            rf_d.ctrl    = bus_wdata & ~SELF_CLR;
            rf_d.ecc_clr = bus_wdata[CTL_CLR_ECC];
        end
        if (bus_wr && bus_addr == ADDR_W'(OFF_TIM0)) rf_d.tim0 = bus_wdata;
        if (bus_wr && bus_addr == ADDR_W'(OFF_TIM1)) rf_d.tim1 = bus_wdata;
        if (wr_ctrl && bus_wdata[CTL_CLR_PG]) rf_d.pgcnt = '0;
        else rf_d.pgcnt = rf_q.pgcnt + PGCNT_W'(evt_in[ST_PG_CS0]) + PGCNT_W'(evt_in[ST_PG_CS1]);
        if (bus_rd) begin
            rf_d.rdata = '0;
            if (bus_addr == ADDR_W'(OFF_CTRL))  rf_d.rdata = rf_q.ctrl;
            if (bus_addr == ADDR_W'(OFF_TIM0))  rf_d.rdata = rf_q.tim0;
            if (bus_addr == ADDR_W'(OFF_TIM1))  rf_d.rdata = rf_q.tim1;
            if (bus_addr == ADDR_W'(OFF_STAT))  rf_d.rdata = REG_W'(stat_bits);
            if (bus_addr == ADDR_W'(OFF_PGCNT)) rf_d.rdata = REG_W'(rf_q.pgcnt);
            if (bus_addr == ADDR_W'(OFF_DATA))  rf_d.rdata = fifo_rdata;
            for (int i = 0; i < CMD_WORDS; i++) begin
                if (bus_addr == ADDR_W'(OFF_CMD0 + 8'(4 * i)))
                    rf_d.rdata = cmd_words[i*REG_W +: REG_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q      <= '0;
            rf_q.ctrl <= CTRL_RST;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign bus_rdata  = rf_q.rdata;
    assign ctrl_word  = rf_q.ctrl;
    assign timing0    = rf_q.tim0;
    assign timing1    = rf_q.tim1;
    assign ecc_clr    = rf_q.ecc_clr;
    assign fifo_wr    = bus_wr && (bus_addr == ADDR_W'(OFF_DATA));
    assign fifo_rd    = bus_rd && (bus_addr == ADDR_W'(OFF_DATA));
    assign fifo_wdata = bus_wdata;
endmodule

// File: rtl/nrf_checker.sv
module nrf_checker
    import nrf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int STAT_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic [STAT_W-1:0] evt_in,
    input logic [STAT_W-1:0] stat_bits,
    input logic [REG_W-1:0]  ctrl_word,
    input logic              cmd_valid,
    input logic              ecc_clr,
    input logic              irq
);
    logic wr_ctrl_c, wr_stat_c, wr_cmd_c;
    assign wr_ctrl_c = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
    assign wr_stat_c = bus_wr && (bus_addr == ADDR_W'(OFF_STAT));
    assign wr_cmd_c  = bus_wr && (bus_addr == ADDR_W'(OFF_CMD0));

    assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat_c && evt_in == '0) |=> ((stat_bits & $past(bus_wdata[STAT_W-1:0])) == '0));

    assert_evt_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in != '0) |=> ((stat_bits & $past(evt_in)) == $past(evt_in)));

    assert_all_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (&ctrl_word[STAT_W-1:0]) |-> !irq);

    assert_run_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_c && bus_wdata[CTL_RUN] && !ctrl_word[CTL_RUN]) |=> stat_bits[ST_CMDREQ]);

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_idle_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd_c && !ctrl_word[CTL_RUN]) |=> !cmd_valid);

    assert_ecc_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl_c && bus_wdata[CTL_CLR_ECC]) |=> ecc_clr);
endmodule

bind nand_regfront nrf_checker #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_nrf_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .evt_in   (evt_in),
    .stat_bits(stat_bits),
    .ctrl_word(ctrl_word),
    .cmd_valid(cmd_valid),
    .ecc_clr  (ecc_clr),
    .irq      (irq)
);

// File: tb/nand_regfront_bench.sv
module nand_regfront_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [11:0] evt_in = '0;
    logic        cmd_valid, ecc_clr, fifo_wr, fifo_rd, irq;
    logic [95:0] cmd_words;
    logic [31:0] ctrl_word, timing0, timing1, fifo_wdata;
    logic [31:0] fifo_rdata = 32'h5A5A_C3C3;

    int checks = 0, fails = 0;
    logic [31:0] v;
    logic [11:0] exp_st, mask;
    int unsigned seed = 32'd1234;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nand_regfront u_nand_regfront (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_in(evt_in), .cmd_valid(cmd_valid), .cmd_words(cmd_words),
        .ctrl_word(ctrl_word), .timing0(timing0), .timing1(timing1),
        .ecc_clr(ecc_clr), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [11:0] e);
        evt_in = e;
        @(negedge clk);
        evt_in = '0;
    endtask

    function automatic logic irq_model(input logic [11:0] st, input logic [11:0] m);
        return |(st & ~m);
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); chk("R1 ctrl", v, 32'h0000_0FFF);
        rd(8'h14, v); chk("R1 status", v, 0);
        rd(8'h18, v); chk("R1 pgcnt", v, 0);
        chk("R1 irq", irq, 0);

        // R12 timing words
        wr(8'h04, 32'h1234_5678); wr(8'h0C, 32'h0BAD_F00D);
        rd(8'h04, v); chk("R12 tim0", v, 32'h1234_5678);
        rd(8'h0C, v); chk("R12 tim1", v, 32'h0BAD_F00D);
        chk("R12 timing1 port", timing1, 32'h0BAD_F00D);

        // R5 R7 R6 command load
        wr(8'h00, 32'h1000_0FFF);
        rd(8'h14, v); chk("R5 cmd request", v, 32'h001);
        wr(8'h48, 32'hAAAA_0001);
        chk("R6 no early valid", cmd_valid, 0);
        rd(8'h14, v); chk("R7 request cleared", v, 0);
        wr(8'h48, 32'hBBBB_0002);
        chk("R6 no early valid", cmd_valid, 0);
        wr(8'h48, 32'hCCCC_0003);
        chk("R6 valid", cmd_valid, 1);
        chk("R6 words", cmd_words, {32'hCCCC_0003, 32'hBBBB_0002, 32'hAAAA_0001});
        @(negedge clk);
        chk("R6 pulse width", cmd_valid, 0);
        rd(8'h4C, v); chk("R6 readback word1", v, 32'hBBBB_0002);

        // R8 ignored writes
        wr(8'h4C, 32'hDEAD_BEEF);
        rd(8'h4C, v); chk("R8 0x4C ignored", v, 32'hBBBB_0002);
        wr(8'h00, 32'h0000_0FFF);
        for (int i = 0; i < 3; i++) begin
            wr(8'h48, 32'h7777_0000 + i);
            chk("R8 idle write ignored", cmd_valid, 0);
        end
        rd(8'h48, v); chk("R8 word0 kept", v, 32'hAAAA_0001);
        wr(8'h00, 32'h1000_0FFF);
        wr(8'h48, 32'hD0D0_0001);
        chk("R8 counter not advanced", cmd_valid, 0);
        wr(8'h48, 32'hD0D0_0002);
        chk("R8 counter not advanced", cmd_valid, 0);

        // R9 abort
        wr(8'h00, 32'h0000_0FFF);
        wr(8'h00, 32'h1000_0FFF);
        wr(8'h48, 32'hF000_0001);
        chk("R9 abort reset counter", cmd_valid, 0);
        wr(8'h48, 32'hF000_0002);
        chk("R9 abort reset counter", cmd_valid, 0);
        wr(8'h48, 32'hF000_0003);
        chk("R9 valid after fresh three", cmd_valid, 1);
        chk("R9 words", cmd_words, {32'hF000_0003, 32'hF000_0002, 32'hF000_0001});
        wr(8'h00, 32'h0000_0FFF);

        // R3 R2 sticky status
        wr(8'h14, 32'hFFF);
        pulse(12'h028);
        rd(8'h14, v); chk("R3 event sets", v, 32'h028);
        wr(8'h14, 32'h008);
        rd(8'h14, v); chk("R2 w1c partial", v, 32'h020);
        evt_in = 12'h020; bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h020;
        @(negedge clk);
        evt_in = '0; bus_wr = 1'b0;
        rd(8'h14, v); chk("R3 event beats clear", v, 32'h020);
        wr(8'h14, 32'hFFF);

        // R4 mask polarity
        wr(8'h00, 32'h0000_0FDF);
        chk("R4 no status no irq", irq, 0);
        pulse(12'h020);
        chk("R4 unmasked raises irq", irq, 1);
        wr(8'h14, 32'h020);
        pulse(12'h040);
        chk("R4 masked bit silent", irq, 0);
        wr(8'h14, 32'hFFF);

        // R10 page counter and ecc clear
        pulse(12'h600); pulse(12'h400);
        rd(8'h18, v); chk("R10 page count", v, 3);
        wr(8'h00, 32'h0010_0FFF);
        rd(8'h18, v); chk("R10 page clear", v, 0);
        rd(8'h00, v); chk("R10 self clear bits", v, 32'h0000_0FFF);
        wr(8'h00, 32'h0008_0FFF);
        chk("R10 ecc pulse", ecc_clr, 1);
        @(negedge clk);
        chk("R10 ecc pulse ends", ecc_clr, 0);
        wr(8'h14, 32'hFFF);

        // R11 data pass-through
        bus_wr = 1'b1; bus_addr = 8'h40; bus_wdata = 32'h0102_0304;
        #1;
        chk("R11 fifo_wr", fifo_wr, 1);
        chk("R11 fifo_wdata", fifo_wdata, 32'h0102_0304);
        @(negedge clk); bus_wr = 1'b0;
        bus_rd = 1'b1; bus_addr = 8'h40;
        #1;
        chk("R11 fifo_rd", fifo_rd, 1);
        @(negedge clk); bus_rd = 1'b0;
        chk("R11 read data", bus_rdata, 32'h5A5A_C3C3);

        // random status / mask traffic (R2 R3 R4)
        void'($urandom(seed));
        exp_st = '0;
        for (int n = 0; n < 150; n++) begin
            logic [11:0] e, c;
            if (n % 25 == 0) begin
                mask = 12'($urandom);
                wr(8'h00, {20'h0, mask});
            end
            e = 12'($urandom) & 12'($urandom) & 12'($urandom);
            c = 12'($urandom);
            evt_in = e; bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = {20'h0, c};
            @(negedge clk);
            evt_in = '0; bus_wr = 1'b0;
            exp_st = (exp_st & ~c) | e;
            chk("R4 random irq", irq, irq_model(exp_st, mask));
            rd(8'h14, v); chk("R2 R3 random status", v, {20'h0, exp_st});
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule